// File: doc/BRIEF.md
# Receive Performance Report Message Decoder

This block watches the receive facility data link, a serial bit stream qualified by a per-bit valid strobe. It recovers scheduled performance report messages from that stream. It finds the framing flags, removes the zero bits the sender inserted after runs of five ones, and drops any frame that an abort sequence ends. For each closed frame it checks the length and the CRC-16. It then updates a four-deep, one-second history of the remote end's status bytes.

A good message places its current-second status byte at the head of the history, and every older entry moves one place down. A message that fails its checks puts an all-zero marker at the head instead and bumps a saturating error counter. If the next message is good, the second that was lost is filled in from that message's previous-second octet. A one-second tick input tells the block when a second has gone by. If no message of any kind arrived during that second, the framing-error flags are forced on in every history entry. All history entries and the counter are exposed as plain outputs.

Top module: `prm_rx_decoder`

## Requirements
- R1: A frame is the bit run between two flags (0x7E, sent least significant bit first). One flag may both close a frame and open the next. Two flags with no whole byte between them produce no message.
- R2: Within a frame, a 0 that follows five consecutive 1s is removed before the bytes are assembled. Bytes are assembled least significant bit first.
- R3: CRC-16 (polynomial x^16+x^12+x^5+1, preset all ones, result inverted, check word sent low byte first) is run over every byte between the flags, check word included. A frame is good only if the running value ends at 0xF0B8.
- R4: A frame is also errored when it does not hold exactly MSG_BYTES whole bytes (default 13: eleven message bytes plus the check word), or when bits are left over beyond the last whole byte.
- R5: A good frame loads the data byte at index CUR_IDX (default 3, zero-based after the opening flag) into history entry 0. Each entry's layout is bit 7 payload loopback, bit 6 slip, bit 5 line violation, bit 4 severe framing error, bit 3 frame bit error, bits 2:0 the CRC-6 event code.
- R6: Every good or errored frame shifts the history: entry 0 to 1, 1 to 2, 2 to 3, and the old entry 3 is lost.
- R7: An errored frame writes 0x00 into entry 0 and increments the error counter, which holds at 255.
- R8: A good frame that directly follows an errored frame writes its data byte at index PREV_IDX (default 5) into entry 1 instead of the shifted marker.
- R9: Seven or more consecutive 1s abort the open frame. The aborted frame changes neither the history nor the counter, and the receiver waits for the next flag.
- R10: On a sec_tick pulse, if no frame (good or errored) finished since the previous tick or since reset, bits 4 and 3 are set in all four entries. Otherwise the history is unchanged.
- R11: After reset all four entries and the error counter read zero.
- R12: A cycle with bit_valid low does not advance the receiver, whatever bit_in carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial data link bit |
| bit_valid | input | 1 | bit_in carries a new bit this cycle |
| sec_tick | input | 1 | One-cycle pulse marking the end of each second |
| hist0 | output | 8 | Newest history entry |
| hist1 | output | 8 | History entry one second older |
| hist2 | output | 8 | History entry two seconds older |
| hist3 | output | 8 | Oldest history entry |
| err_count | output | 8 | Saturating count of errored frames |

## Verification
The bench uses the default parameters: thirteen bytes per frame, status and backfill bytes at indices 3 and 5, and an 8-bit error counter. The 8-bit status entry allows every one of its 256 values to be driven through the history in a single sweep, with an errored frame mixed in at regular points so that backfill is exercised. Each swept value also produces a different check word, which covers many stuffing patterns. With the short counter, saturation can be reached cheaply using one-byte frames that fail the length check. Abort, shared flags, leftover bits and tick handling are each run as directed cases.

// File: rtl/prm_pkg.sv
// Package: shared constants and the CRC-16 step for the message decoder.
// Assumes reflected (least significant bit first) bit order on the link.
package prm_pkg;
    localparam int STAT_W     = 8;
    localparam int HIST_DEPTH = 4;
    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_R  = 16'h8408;
    localparam logic [STAT_W-1:0] NO_MSG_MASK = 8'h18;

    typedef logic [STAT_W-1:0] stat_t;

    // Advance the reflected CRC-16 by one byte, least significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ data[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_R;
        end
        return c;
    endfunction
endpackage

// File: rtl/prm_hdlc_deframer.sv
// Module: flag hunt, zero removal and abort detection on the serial link.
// Emits each whole byte, a pulse per flag (with an alignment flag) and a
// pulse per abort of an open frame. Assumes one bit per bit_valid cycle.
// The closing flag's first six bits enter the byte shifter before they are
// recognised; a frame is whole only if exactly six such bits are pending.
module prm_hdlc_deframer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_in,
    input  logic       bit_valid,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       flag_pulse,
    output logic       flag_aligned,
    output logic       abort_pulse
);
    localparam logic [2:0] STUFF_RUN = 3'd5;
    localparam logic [2:0] FLAG_RUN  = 3'd6;
    localparam logic [2:0] RUN_MAX   = 3'd7;
    localparam logic [2:0] FLAG_TAIL = 3'd6;

    logic [2:0] ones_q;
    logic       in_frame_q;
    logic [7:0] shift_q;
    logic [2:0] pcnt_q;
    logic       data_take, flag_hit, abort_hit;
    logic [7:0] shift_next;

    // Classify the incoming bit: data, flag end, abort or stuffed zero.
    always_comb begin
        flag_hit   = bit_valid && !bit_in && (ones_q == FLAG_RUN);
        abort_hit  = bit_valid &&  bit_in && (ones_q == FLAG_RUN);
        data_take  = bit_valid && in_frame_q &&
                     ((bit_in && ones_q < STUFF_RUN) ||
                      (!bit_in && ones_q != STUFF_RUN && ones_q != FLAG_RUN));
        shift_next = {bit_in, shift_q[7:1]};
    end

    // Track the run of ones, frame state, byte assembly and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q       <= '0;
            in_frame_q   <= 1'b0;
            shift_q      <= '0;
            pcnt_q       <= '0;
            byte_vld     <= 1'b0;
            byte_data    <= '0;
            flag_pulse   <= 1'b0;
            flag_aligned <= 1'b0;
            abort_pulse  <= 1'b0;
        end else begin
            byte_vld    <= 1'b0;
            flag_pulse  <= 1'b0;
            abort_pulse <= 1'b0;
            if (bit_valid) begin
                if (!bit_in)                ones_q <= '0;
                else if (ones_q != RUN_MAX) ones_q <= ones_q + 3'd1;
            end
            if (data_take) begin
                shift_q <= shift_next;
                if (pcnt_q == 3'd7) begin
                    pcnt_q    <= '0;
                    byte_vld  <= 1'b1;
                    byte_data <= shift_next;
                end else begin
                    pcnt_q <= pcnt_q + 3'd1;
                end
            end
            if (flag_hit) begin
                flag_pulse   <= 1'b1;
                flag_aligned <= in_frame_q && (pcnt_q == FLAG_TAIL);
                in_frame_q   <= 1'b1;
                pcnt_q       <= '0;
            end
            if (abort_hit) begin
                abort_pulse <= in_frame_q;
                in_frame_q  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/prm_frame_check.sv
// Module: per-frame CRC-16 residue check, byte count and field capture.
// Emits one good or bad pulse per closed frame that held at least one byte.
// Assumes a byte strobe never coincides with a flag or abort pulse.
module prm_frame_check #(
    parameter int MSG_BYTES = 13,
    parameter int CUR_IDX   = 3,
    parameter int PREV_IDX  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 byte_vld,
    input  logic [7:0]           byte_data,
    input  logic                 flag_pulse,
    input  logic                 flag_aligned,
    input  logic                 abort_pulse,
    output logic                 msg_good,
    output logic                 msg_bad,
    output prm_pkg::stat_t       cur_byte,
    output prm_pkg::stat_t       prev_byte
);
    import prm_pkg::*;

    localparam int CNT_W = $clog2(MSG_BYTES + 2);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MSG_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MSG_BYTES);
    localparam logic [CNT_W-1:0] CUR_AT   = CNT_W'(CUR_IDX);
    localparam logic [CNT_W-1:0] PREV_AT  = CNT_W'(PREV_IDX);

    logic [15:0]      crc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             frame_ok;

    // A frame is good when whole, of the right length and CRC-clean.
    always_comb frame_ok = flag_aligned && (cnt_q == CNT_FULL) && (crc_q == CRC_RESIDUE);

    // Accumulate CRC and count per byte; judge and restart on each flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q     <= CRC_PRESET;
            cnt_q     <= '0;
            cur_byte  <= '0;
            prev_byte <= '0;
            msg_good  <= 1'b0;
            msg_bad   <= 1'b0;
        end else begin
            msg_good <= 1'b0;
            msg_bad  <= 1'b0;
            if (byte_vld) begin
                crc_q <= crc16_step(crc_q, byte_data);
                if (cnt_q != CNT_SAT)  cnt_q     <= cnt_q + CNT_W'(1);
                if (cnt_q == CUR_AT)   cur_byte  <= byte_data;
                if (cnt_q == PREV_AT)  prev_byte <= byte_data;
            end
            if (flag_pulse) begin
                if (cnt_q != '0) begin
                    msg_good <= frame_ok;
                    msg_bad  <= !frame_ok;
                end
                crc_q <= CRC_PRESET;
                cnt_q <= '0;
            end
            if (abort_pulse) begin
                crc_q <= CRC_PRESET;
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/prm_history.sv
// Module: one-second status history chain and errored-frame counter.
// Assumes a message pulse and sec_tick do not both carry meaning for the
// no-message rule: a message in the tick cycle counts as seen.
module prm_history #(
    parameter int ERR_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  msg_good,
    input  logic                                  msg_bad,
    input  prm_pkg::stat_t                        cur_byte,
    input  prm_pkg::stat_t                        prev_byte,
    input  logic                                  sec_tick,
    output prm_pkg::stat_t [prm_pkg::HIST_DEPTH-1:0] hist,
    output logic [ERR_W-1:0]                      err_count
);
    import prm_pkg::*;

    logic miss_q;
    logic seen_q;

    // Shift the chain on each message, or mark a silent second on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist   <= '0;
            miss_q <= 1'b0;
        end else if (msg_good || msg_bad) begin
            for (int i = HIST_DEPTH - 1; i >= 2; i--) hist[i] <= hist[i-1];
            hist[1] <= (msg_good && miss_q) ? prev_byte : hist[0];
            hist[0] <= msg_good ? cur_byte : '0;
            miss_q  <= msg_bad;
        end else if (sec_tick && !seen_q) begin
            for (int i = 0; i < HIST_DEPTH; i++) hist[i] <= hist[i] | NO_MSG_MASK;
        end
    end

    // Count errored frames, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                          err_count <= '0;
        else if (msg_bad && err_count != '1) err_count <= err_count + ERR_W'(1);
    end

    // Remember whether any frame finished during the current second.
    always_ff @(posedge clk) begin
        if (!rst_n)                     seen_q <= 1'b0;
        else if (sec_tick)              seen_q <= 1'b0;
        else if (msg_good || msg_bad)   seen_q <= 1'b1;
    end
endmodule

// File: rtl/prm_rx_decoder.sv
// Module: top of the receive report-message decoder. Chains the deframer,
// the frame checker and the history. Assumes bit_in is already synchronous.
module prm_rx_decoder #(
    parameter int MSG_BYTES = 13,
    parameter int CUR_IDX   = 3,
    parameter int PREV_IDX  = 5,
    parameter int ERR_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_valid,
    input  logic             sec_tick,
    output logic [7:0]       hist0,
    output logic [7:0]       hist1,
    output logic [7:0]       hist2,
    output logic [7:0]       hist3,
    output logic [ERR_W-1:0] err_count
);
    import prm_pkg::*;

    logic       byte_vld;
    logic [7:0] byte_data;
    logic       flag_pulse, flag_aligned, abort_pulse;
    logic       msg_good, msg_bad;
    stat_t      cur_byte, prev_byte;
    stat_t [HIST_DEPTH-1:0] hist;

    prm_hdlc_deframer u_deframer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_in       (bit_in),
        .bit_valid    (bit_valid),
        .byte_vld     (byte_vld),
        .byte_data    (byte_data),
        .flag_pulse   (flag_pulse),
        .flag_aligned (flag_aligned),
        .abort_pulse  (abort_pulse)
    );

    prm_frame_check #(
        .MSG_BYTES (MSG_BYTES),
        .CUR_IDX   (CUR_IDX),
        .PREV_IDX  (PREV_IDX)
    ) u_check (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_vld     (byte_vld),
        .byte_data    (byte_data),
        .flag_pulse   (flag_pulse),
        .flag_aligned (flag_aligned),
        .abort_pulse  (abort_pulse),
        .msg_good     (msg_good),
        .msg_bad      (msg_bad),
        .cur_byte     (cur_byte),
        .prev_byte    (prev_byte)
    );

    prm_history #(
        .ERR_W (ERR_W)
    ) u_history (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_good  (msg_good),
        .msg_bad   (msg_bad),
        .cur_byte  (cur_byte),
        .prev_byte (prev_byte),
        .sec_tick  (sec_tick),
        .hist      (hist),
        .err_count (err_count)
    );

    assign hist0 = hist[0];
    assign hist1 = hist[1];
    assign hist2 = hist[2];
    assign hist3 = hist[3];
endmodule

// File: rtl/prm_rx_decoder_sva.sv
// Module: property checker for the decoder, attached by bind below.
module prm_rx_decoder_sva #(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_valid,
    input logic             byte_vld,
    input logic             msg_good,
    input logic             msg_bad,
    input logic [7:0]       cur_byte,
    input logic [7:0]       hist0,
    input logic [7:0]       hist1,
    input logic [7:0]       hist2,
    input logic [7:0]       hist3,
    input logic [ERR_W-1:0] err_count
);
    assert_idle_no_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> !byte_vld);

    assert_verdict_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_good && msg_bad));

    assert_good_loads_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_good |=> hist0 == $past(cur_byte));

    assert_chain_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_good || msg_bad) |=> (hist2 == $past(hist1)) && (hist3 == $past(hist2)));

    assert_bad_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_bad |=> hist0 == 8'h00);

    assert_err_increment_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_bad && err_count != '1) |=> err_count == ERR_W'($past(err_count) + ERR_W'(1)));

    assert_err_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_bad |=> $stable(err_count));
endmodule

bind prm_rx_decoder prm_rx_decoder_sva #(.ERR_W(ERR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .byte_vld  (byte_vld),
    .msg_good  (msg_good),
    .msg_bad   (msg_bad),
    .cur_byte  (cur_byte),
    .hist0     (hist0),
    .hist1     (hist1),
    .hist2     (hist2),
    .hist3     (hist3),
    .err_count (err_count)
);

// File: tb/prm_rx_decoder_bench.sv
module prm_rx_decoder_bench;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, bit_in, bit_valid, sec_tick;
    logic [7:0] hist0, hist1, hist2, hist3, err_count;

    prm_rx_decoder u_prm_rx_decoder (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .sec_tick(sec_tick), .hist0(hist0), .hist1(hist1), .hist2(hist2),
        .hist3(hist3), .err_count(err_count)
    );

    int total = 0;
    int bad = 0;
    int ones_run = 0;
    bit gap_mode = 0;
    int gap_ctr = 0;
    logic [7:0] msg [0:15];
    logic [7:0] e_h [0:3];
    logic [7:0] e_err;
    bit e_miss, e_seen;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " hist0"}, hist0, e_h[0]);
        chk({tag, " hist1"}, hist1, e_h[1]);
        chk({tag, " hist2"}, hist2, e_h[2]);
        chk({tag, " hist3"}, hist3, e_h[3]);
        chk({tag, " err_count"}, err_count, e_err);
    endtask

    // Reference model of the history (R5..R8, R10).
    task automatic m_good(input logic [7:0] cur, input logic [7:0] prev);
        e_h[3] = e_h[2]; e_h[2] = e_h[1];
        e_h[1] = e_miss ? prev : e_h[0];
        e_h[0] = cur; e_miss = 0; e_seen = 1;
    endtask
    task automatic m_bad();
        e_h[3] = e_h[2]; e_h[2] = e_h[1]; e_h[1] = e_h[0]; e_h[0] = 8'h00;
        if (e_err != 8'hFF) e_err = e_err + 8'd1;
        e_miss = 1; e_seen = 1;
    endtask

    task automatic put_bit(input logic b);
        if (gap_mode) begin
            gap_ctr++;
            if (gap_ctr % 3 == 0) begin
                @(negedge clk); bit_valid = 0; bit_in = ~b;   // R12 garbage
            end
        end
        @(negedge clk); bit_in = b; bit_valid = 1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); bit_valid = 0; bit_in = 1; end
    endtask

    task automatic put_flag();
        logic [7:0] f = 8'h7E;
        for (int i = 0; i < 8; i++) put_bit(f[i]);
        ones_run = 0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            put_bit(b[i]);
            if (b[i]) begin
                ones_run++;
                if (ones_run == 5) begin put_bit(1'b0); ones_run = 0; end
            end else ones_run = 0;
        end
    endtask

    function automatic logic [15:0] crc_of(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++)
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ msg[k][i];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        return c;
    endfunction

    task automatic fill(input logic [7:0] cur, input logic [7:0] prev, input int seed);
        for (int k = 0; k < 16; k++) msg[k] = 8'(seed * 13 + k * 29 + 5);
        msg[3] = cur;
        msg[5] = prev;
    endtask

    // Send n message bytes plus check word; optional open flag, pad bits, corruption.
    task automatic send_frame(input int n, input bit open_flag, input int pad, input bit flip);
        logic [15:0] fcs = ~crc_of(n);
        if (open_flag) put_flag();
        for (int k = 0; k < n; k++) put_byte(k == 2 && flip ? msg[k] ^ 8'h01 : msg[k]);
        put_byte(fcs[7:0]);
        put_byte(fcs[15:8]);
        for (int p = 0; p < pad; p++) begin put_bit(1'b0); ones_run = 0; end
        put_flag();
        idle(5);
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
        idle(2);
        if (!e_seen) for (int i = 0; i < 4; i++) e_h[i] = e_h[i] | 8'h18;
        e_seen = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; bit_in = 0; bit_valid = 0; sec_tick = 0;
        for (int i = 0; i < 4; i++) e_h[i] = 8'h00;
        e_err = 0; e_miss = 0; e_seen = 0;
        idle(5);
        @(negedge clk); rst_n = 1;
        idle(2);
        chk_all("R11 reset");

        // R10: a silent second flags all entries.
        tick();
        chk_all("R10 silent second");

        // R5 R6 R8 R3 R2: sweep every status value, errored frame every 16th.
        for (int v = 0; v < 256; v++) begin
            bit flip = (v % 16 == 7);
            fill(8'(v), 8'(~v), v);
            send_frame(11, 1, 0, flip);
            if (flip) m_bad(); else m_good(8'(v), 8'(~v));
            chk("R5 head", hist0, e_h[0]);
            chk("R8 R6 entry1", hist1, e_h[1]);
            chk("R6 entry3", hist3, e_h[3]);
            chk("R3 R7 err", err_count, e_err);
            if (v % 64 == 63) begin
                tick();
                chk_all("R10 busy second");
            end
        end

        // R1: frame opened by previous closing flag, and back-to-back flags.
        fill(8'hA5, 8'h3C, 300);
        send_frame(11, 0, 0, 0);
        m_good(8'hA5, 8'h3C);
        chk_all("R1 shared flag");
        put_flag(); put_flag(); put_flag(); idle(5);
        chk_all("R1 empty frames");

        // R4: wrong length with a valid check word, then backfill R8.
        fill(8'h11, 8'h22, 301);
        send_frame(10, 1, 0, 0);
        m_bad();
        chk_all("R4 short frame");
        fill(8'h33, 8'hC7, 302);
        send_frame(11, 1, 0, 0);
        m_good(8'h33, 8'hC7);
        chk_all("R8 backfill");

        // R4: leftover bits beyond the last whole byte.
        fill(8'h44, 8'h55, 303);
        send_frame(11, 1, 3, 0);
        m_bad();
        chk_all("R4 leftover bits");

        // R9: abort in the middle of a frame.
        put_flag();
        for (int k = 0; k < 4; k++) put_byte(8'h5A);
        for (int k = 0; k < 9; k++) put_bit(1'b1);
        idle(5);
        chk_all("R9 abort");
        fill(8'h66, 8'h77, 304);
        send_frame(11, 1, 0, 0);
        m_good(8'h66, 8'h77);
        chk_all("R9 after abort");

        // R12: invalid cycles with garbage bits between real ones.
        gap_mode = 1;
        for (int v = 0; v < 4; v++) begin
            fill(8'(v * 40 + 9), 8'(v * 7), 400 + v);
            send_frame(11, 1, 0, 0);
            m_good(8'(v * 40 + 9), 8'(v * 7));
            chk_all("R12 gaps");
        end
        gap_mode = 0;

        // R7: saturation using one-byte frames.
        for (int k = 0; k < 256; k++) begin
            put_flag(); put_byte(8'h55); put_flag(); idle(5);
            m_bad();
        end
        chk_all("R7 saturation");

        // R10: busy second then silent second.
        tick();
        chk_all("R10 busy");
        tick();
        chk_all("R10 silent");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule